// File: doc/BRIEF.md
# Character Grid Display Renderer

This block turns a stream of raster pixel coordinates into a monochrome pixel bit for a text screen of 40 columns by 25 rows. Each character cell is 8 by 8 pixels, so the text area covers 320 by 200 pixels. An external raster timing generator supplies the coordinate, a display-enable flag and a one-cycle pulse at the start of vertical blank. Character codes are held in an internal text store of 50 rows. Glyph bitmaps are held in a writable font memory of 256 glyphs with 8 lines each.

The text store can be used in two ways, chosen by a mode bit. In scroll mode it is a ring of 50 rows, and the first displayed row comes from a start-row register, so software can scroll the screen without copying any data. In page mode it holds two complete 25-row screens, and a page bit chooses which one is shown. A hardware cursor inverts the bottom pixel line of one cell and blinks, with a rate set by a frame counter.

Software drives one write port. The port has a 3-bit target code, an address and a data byte. Each write goes to the text store, the font memory or one of the control registers.

Top module: `tmd_top`

## Requirements
- R1: `pix_out` is 0 whenever the display-enable sampled two clocks earlier was low, or when the coordinate from that time had x >= 320 or y >= 200.
- R2: For a coordinate inside the area, `pix_out` appears two clocks after the coordinate is presented. Its value is bit (7 - x%8) of font byte code*8 + y%8, where code is the character of the displayed cell. Bit 7 is the leftmost pixel.
- R3: Page mode is selected by control bit 0 = 0. In this mode, screen row r (= y/8) is read from store row r when control bit 1 is 0, and from store row 25 + r when control bit 1 is 1.
- R4: Scroll mode is selected by control bit 0 = 1. In this mode, screen row r is read from store row (start + r) mod 50.
- R5: Target 0 writes the character byte at store address row*40 + column. A write with address >= 2000 changes nothing.
- R6: Target 1 writes font byte address glyph*8 + line, for addresses below 2048. A change is visible at the next read of that glyph line.
- R7: Target 2 sets the cursor column and target 3 sets the cursor row. Both are screen positions, counted before scrolling. While the cursor is visible, the pixels of line 7 of that cell are inverted. Other lines and other cells are not affected.
- R8: The cursor is visible after reset. Every 16 vertical-blank pulses its visibility inverts: it is hidden after pulses 16 to 31 and visible again after pulse 32.
- R9: Target 5 sets the start row. A value of 50 or more is ignored and the previous start row stays in force. Target 4 writes the control byte (bit 0 mode, bit 1 page).
- R10: If a text write hits the cell that is being read in the same clock, the pixel for that coordinate shows the old character. The next read of the cell shows the new one.
- R11: After reset, `pix_out` is 0, page mode with page 0 is active, the start row is 0, and the cursor is at column 0, row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| px_x | input | 10 | Raster x coordinate |
| px_y | input | 10 | Raster y coordinate |
| px_de | input | 1 | Display enable for the current coordinate |
| frame_tick | input | 1 | One-cycle pulse at the start of vertical blank |
| cpu_we | input | 1 | Write strobe |
| cpu_tgt | input | 3 | Write target: 0 text, 1 font, 2 cursor column, 3 cursor row, 4 control, 5 start row |
| cpu_addr | input | 12 | Store or font address for targets 0 and 1 |
| cpu_data | input | 8 | Write data |
| pix_out | output | 1 | Monochrome pixel, two clocks after its coordinate |

## Verification
The collision that matters is a software write to the text store in the same clock in which the raster reads the same cell. The bench provokes it by putting a coordinate and a write to that cell's address on the same edge, using two glyphs whose lines are all ones and all zeros. It then expects the old glyph's pixel after two clocks and the new glyph's pixel one clock later. A second overlap, between a vertical-blank pulse and a displayed cursor pixel, is judged by counting pulses in the bench model and checking cursor-line pixels across the 16-pulse boundary.

// File: rtl/tmd_pkg.sv
package tmd_pkg;
    typedef enum logic [2:0] {
        TGT_TEXT  = 3'd0,
        TGT_FONT  = 3'd1,
        TGT_CCOL  = 3'd2,
        TGT_CROW  = 3'd3,
        TGT_CTRL  = 3'd4,
        TGT_START = 3'd5
    } tgt_e;
endpackage

// File: rtl/tmd_regs.sv
// Control registers and the cursor blink divider.
module tmd_regs
    import tmd_pkg::*;
#(
    parameter int ROWS         = 25,
    parameter int BLINK_FRAMES = 16,
    localparam int RING        = 2 * ROWS,
    localparam int ROW_W       = $clog2(RING),
    localparam int FC_W        = $clog2(BLINK_FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       tgt,
    input  logic [7:0]       wdata,
    input  logic             frame_tick,
    output logic [7:0]       cur_col,
    output logic [7:0]       cur_row,
    output logic             scroll_mode,
    output logic             page_sel,
    output logic [ROW_W-1:0] start_row,
    output logic             blink_on
);
    localparam logic [7:0]      RING_B = 8'(RING);
    localparam logic [FC_W-1:0] FC_TOP = FC_W'(BLINK_FRAMES - 1);

    typedef struct packed {
        logic [7:0]       ccol;
        logic [7:0]       crow;
        logic             smode;
        logic             page;
        logic [ROW_W-1:0] start;
        logic [FC_W-1:0]  fcnt;
        logic             blink;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            unique case (tgt)
                TGT_CCOL:  st_d.ccol = wdata;
                TGT_CROW:  st_d.crow = wdata;
                TGT_CTRL: begin
                    st_d.smode = wdata[0];
                    st_d.page  = wdata[1];
                end
                TGT_START: if (wdata < RING_B) st_d.start = wdata[ROW_W-1:0];
                default: ;
            endcase
        end
        if (frame_tick) begin
            if (st_q.fcnt == FC_TOP) begin
                st_d.fcnt  = '0;
                st_d.blink = ~st_q.blink;
            end else begin
                st_d.fcnt = st_q.fcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.blink <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_col     = st_q.ccol;
    assign cur_row     = st_q.crow;
    assign scroll_mode = st_q.smode;
    assign page_sel    = st_q.page;
    assign start_row   = st_q.start;
    assign blink_on    = st_q.blink;
endmodule

// File: rtl/tmd_addr.sv
// Maps a raster coordinate to a cell, a glyph line and a store address.
module tmd_addr #(
    parameter int COLS = 40,
    parameter int ROWS = 25,
    parameter int GW   = 8,
    parameter int GH   = 8,
    parameter int XW   = 10,
    localparam int RING   = 2 * ROWS,
    localparam int ROW_W  = $clog2(RING),
    localparam int TDEPTH = RING * COLS,
    localparam int TA_W   = $clog2(TDEPTH),
    localparam int GX_SH  = $clog2(GW),
    localparam int GY_SH  = $clog2(GH)
) (
    input  logic [XW-1:0]    x,
    input  logic [XW-1:0]    y,
    input  logic             scroll_mode,
    input  logic             page_sel,
    input  logic [ROW_W-1:0] start_row,
    output logic             in_area,
    output logic [7:0]       col,
    output logic [7:0]       row,
    output logic [GY_SH-1:0] line,
    output logic [GX_SH-1:0] bsel,
    output logic [TA_W-1:0]  taddr
);
    localparam logic [XW-1:0] X_LIM  = XW'(COLS * GW);
    localparam logic [XW-1:0] Y_LIM  = XW'(ROWS * GH);
    localparam logic [7:0]    RING_B = 8'(RING);
    localparam logic [7:0]    ROWS_B = 8'(ROWS);

    logic [7:0]  sum;
    logic [7:0]  prow;
    logic [15:0] lin;

    always_comb begin
        in_area = (x < X_LIM) && (y < Y_LIM);
        col     = 8'(x >> GX_SH);
        row     = 8'(y >> GY_SH);
        line    = y[GY_SH-1:0];
        bsel    = x[GX_SH-1:0];
        sum     = 8'(start_row) + row;
        if (sum >= RING_B) sum = sum - RING_B;
        if (scroll_mode) prow = sum;
        else             prow = page_sel ? (row + ROWS_B) : row;
        lin   = 16'(prow) * 16'(COLS) + 16'(col);
        taddr = in_area ? TA_W'(lin) : '0;
    end
endmodule

// File: rtl/tmd_ram.sv
// Single-clock memory, one write port and one registered read port.
// A read and a write to the same address in one clock return the old data.
module tmd_ram #(
    parameter int DEPTH = 2000,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tmd_top.sv
module tmd_top
    import tmd_pkg::*;
#(
    parameter int COLS         = 40,
    parameter int ROWS         = 25,
    parameter int GW           = 8,
    parameter int GH           = 8,
    parameter int NGLYPH       = 256,
    parameter int XW           = 10,
    parameter int AW           = 12,
    parameter int BLINK_FRAMES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] px_x,
    input  logic [XW-1:0] px_y,
    input  logic          px_de,
    input  logic          frame_tick,
    input  logic          cpu_we,
    input  logic [2:0]    cpu_tgt,
    input  logic [AW-1:0] cpu_addr,
    input  logic [7:0]    cpu_data,
    output logic          pix_out
);
    localparam int RING   = 2 * ROWS;
    localparam int ROW_W  = $clog2(RING);
    localparam int TDEPTH = RING * COLS;
    localparam int TA_W   = $clog2(TDEPTH);
    localparam int FDEPTH = NGLYPH * GH;
    localparam int FA_W   = $clog2(FDEPTH);
    localparam int GX_SH  = $clog2(GW);
    localparam int GY_SH  = $clog2(GH);
    localparam logic [AW-1:0]    T_LIM    = AW'(TDEPTH);
    localparam logic [AW-1:0]    F_LIM    = AW'(FDEPTH);
    localparam logic [GY_SH-1:0] CUR_LINE = GY_SH'(GH - 1);
    localparam logic [GX_SH-1:0] MSB_IDX  = GX_SH'(GW - 1);

    typedef struct packed {
        logic             de;
        logic             area;
        logic [GX_SH-1:0] bsel;
        logic [GY_SH-1:0] line;
        logic             cur;
    } s1_t;

    typedef struct packed {
        logic             de;
        logic             area;
        logic [GX_SH-1:0] bsel;
        logic             cur;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } pipe_t;

    pipe_t pp_d, pp_q;

    logic [7:0]       cur_col, cur_row;
    logic             scroll_mode, page_sel, blink_on;
    logic [ROW_W-1:0] start_row;
    logic             in_area;
    logic [7:0]       col, row;
    logic [GY_SH-1:0] line;
    logic [GX_SH-1:0] bsel;
    logic [TA_W-1:0]  taddr;
    logic [7:0]       char_q;
    logic [GW-1:0]    glyph_q;
    logic             text_we, font_we;
    logic [FA_W-1:0]  faddr;
    logic [15:0]      flin;

    tmd_regs #(.ROWS(ROWS), .BLINK_FRAMES(BLINK_FRAMES)) u_regs (
        .clk(clk), .rst(rst), .we(cpu_we), .tgt(cpu_tgt), .wdata(cpu_data),
        .frame_tick(frame_tick), .cur_col(cur_col), .cur_row(cur_row),
        .scroll_mode(scroll_mode), .page_sel(page_sel),
        .start_row(start_row), .blink_on(blink_on)
    );

    tmd_addr #(.COLS(COLS), .ROWS(ROWS), .GW(GW), .GH(GH), .XW(XW)) u_addr (
        .x(px_x), .y(px_y), .scroll_mode(scroll_mode), .page_sel(page_sel),
        .start_row(start_row), .in_area(in_area), .col(col), .row(row),
        .line(line), .bsel(bsel), .taddr(taddr)
    );

    assign text_we = cpu_we && (cpu_tgt == TGT_TEXT) && (cpu_addr < T_LIM);
    assign font_we = cpu_we && (cpu_tgt == TGT_FONT) && (cpu_addr < F_LIM);

    tmd_ram #(.DEPTH(TDEPTH), .DW(8)) u_text (
        .clk(clk), .we(text_we), .waddr(TA_W'(cpu_addr)), .wdata(cpu_data),
        .raddr(taddr), .rdata(char_q)
    );

    always_comb begin
        flin  = 16'(char_q) * 16'(GH) + 16'(pp_q.s1.line);
        faddr = FA_W'(flin);
    end

    tmd_ram #(.DEPTH(FDEPTH), .DW(GW)) u_font (
        .clk(clk), .we(font_we), .waddr(FA_W'(cpu_addr)), .wdata(GW'(cpu_data)),
        .raddr(faddr), .rdata(glyph_q)
    );

    always_comb begin
        pp_d         = pp_q;
        pp_d.s1.de   = px_de;
        pp_d.s1.area = in_area;
        pp_d.s1.bsel = bsel;
        pp_d.s1.line = line;
        pp_d.s1.cur  = in_area && blink_on && (line == CUR_LINE) &&
                       (col == cur_col) && (row == cur_row);
        pp_d.s2.de   = pp_q.s1.de;
        pp_d.s2.area = pp_q.s1.area;
        pp_d.s2.bsel = pp_q.s1.bsel;
        pp_d.s2.cur  = pp_q.s1.cur;
    end

    always_ff @(posedge clk) begin
        if (rst) pp_q <= '0;
        else     pp_q <= pp_d;
    end

    always_comb begin
        pix_out = pp_q.s2.de && pp_q.s2.area &&
                  (glyph_q[MSB_IDX - pp_q.s2.bsel] ^ pp_q.s2.cur);
    end
endmodule

// File: rtl/tmd_chk.sv
module tmd_chk #(
    parameter int XW    = 10,
    parameter int X_LIM = 320,
    parameter int RING  = 50,
    parameter int ROW_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [XW-1:0]    px_x,
    input logic             px_de,
    input logic             frame_tick,
    input logic             cpu_we,
    input logic [2:0]       cpu_tgt,
    input logic [7:0]       cpu_data,
    input logic             pix_out,
    input logic [ROW_W-1:0] start_row,
    input logic             blink_on,
    input logic             scroll_mode
);
    localparam logic [XW-1:0]    XL = XW'(X_LIM);
    localparam logic [ROW_W-1:0] RL = ROW_W'(RING);

    p_blank_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(px_de, 2) |-> !pix_out);

    p_outside_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(px_x, 2) >= XL) |-> !pix_out);

    p_start_range_r9: assert property (@(posedge clk) disable iff (rst)
        start_row < RL);

    p_blink_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(blink_on));

    p_mode_write_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_tgt == 3'd4) |=> (scroll_mode == $past(cpu_data[0])));
endmodule

bind tmd_top tmd_chk #(.XW(XW), .X_LIM(COLS * GW), .RING(2 * ROWS),
                       .ROW_W($clog2(2 * ROWS))) u_chk (
    .clk(clk), .rst(rst), .px_x(px_x), .px_de(px_de),
    .frame_tick(frame_tick), .cpu_we(cpu_we), .cpu_tgt(cpu_tgt),
    .cpu_data(cpu_data), .pix_out(pix_out), .start_row(start_row),
    .blink_on(blink_on), .scroll_mode(scroll_mode)
);

// File: tb/tb_tmd_top.sv
module tb_tmd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  px_x = '0, px_y = '0;
    logic        px_de = 1'b0, frame_tick = 1'b0;
    logic        cpu_we = 1'b0;
    logic [2:0]  cpu_tgt = '0;
    logic [11:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        pix_out;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model
    logic [7:0] text_m [2000];
    logic [7:0] font_m [2048];
    int ccol = 0, crow = 0, start = 0, ticks = 0;
    bit smode = 0, page = 0;

    always #5 clk = ~clk;

    tmd_top dut (.*);

    function automatic bit exp_pix(int x, int y, bit de);
        int c, r, ln, b, prow;
        logic [7:0] g;
        bit p;
        if (!de || x >= 320 || y >= 200) return 1'b0;
        c = x / 8; r = y / 8; ln = y % 8; b = x % 8;
        prow = smode ? (start + r) % 50 : page * 25 + r;
        g = font_m[text_m[prow * 40 + c] * 8 + ln];
        p = g[7 - b];
        if (ln == 7 && c == ccol && r == crow && ((ticks / 16) % 2 == 0)) p = ~p;
        return p;
    endfunction

    task automatic check(string req, bit act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: pix_out=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cpu_wr(int tgt, int addr, int data);
        @(negedge clk);
        cpu_we = 1'b1; cpu_tgt = 3'(tgt); cpu_addr = 12'(addr); cpu_data = 8'(data);
        @(negedge clk);
        cpu_we = 1'b0;
        case (tgt)
            0: if (addr < 2000) text_m[addr] = 8'(data);
            1: if (addr < 2048) font_m[addr] = 8'(data);
            2: ccol = data;
            3: crow = data;
            4: begin smode = data[0]; page = data[1]; end
            5: if (data < 50) start = data;
            default: ;
        endcase
    endtask

    task automatic px_check(string req, int x, int y, bit de);
        bit e;
        e = exp_pix(x, y, de);
        @(negedge clk);
        px_x = 10'(x); px_y = 10'(y); px_de = de;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(req, pix_out, e);
        px_de = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
        ticks++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R11 reset", pix_out, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 after reset", pix_out, 1'b0);

        for (int i = 0; i < 2048; i++) cpu_wr(1, i, $urandom % 256);
        for (int i = 0; i < 2000; i++) cpu_wr(0, i, $urandom % 256);

        // R11 defaults: page 0, cursor at 0,0 visible
        for (int x = 0; x < 8; x++) px_check("R11 cursor home", x, 7, 1);
        px_check("R11 row0", 12, 3, 1);

        // R1 blanking
        px_check("R1 de low", 20, 20, 0);
        px_check("R1 x edge", 320, 10, 1);
        px_check("R1 y edge", 10, 200, 1);
        px_check("R1 far", 1023, 1023, 1);

        // R2/R6 directed glyph bit order
        cpu_wr(0, 0, 1);
        cpu_wr(1, 8, 8'h80);
        cpu_wr(1, 16, 8'h00);
        cpu_wr(2, 39, 0); cpu_wr(3, 24, 0);
        px_check("R6 font MSB left", 0, 0, 1);
        px_check("R2 bit1", 1, 0, 1);
        cpu_wr(1, 8, 8'hFF);
        px_check("R6 font rewrite", 7, 0, 1);

        // R5 out-of-range text write ignored
        cpu_wr(0, 2048, 2);
        px_check("R5 addr 2048 ignored", 0, 0, 1);
        cpu_wr(0, 2000, 2);
        px_check("R5 addr 2000 ignored", 3, 0, 1);

        // R10 same-cycle write/read of a cell
        @(negedge clk);
        px_x = 10'd2; px_y = 10'd0; px_de = 1'b1;
        cpu_we = 1'b1; cpu_tgt = 3'd0; cpu_addr = 12'd0; cpu_data = 8'd2;
        @(negedge clk);
        cpu_we = 1'b0;
        @(negedge clk);
        check("R10 old char", pix_out, 1'b1);
        @(negedge clk);
        check("R10 new char", pix_out, 1'b0);
        px_de = 1'b0;
        text_m[0] = 8'd2;

        // R3 page select
        cpu_wr(4, 0, 2);
        for (int i = 0; i < 20; i++) px_check("R3 page1", $urandom % 320, $urandom % 200, 1);
        cpu_wr(4, 0, 0);
        for (int i = 0; i < 20; i++) px_check("R3 page0", $urandom % 320, $urandom % 200, 1);

        // R4 scroll with wrap
        cpu_wr(4, 0, 1);
        cpu_wr(5, 0, 49);
        for (int r = 0; r < 25; r++) px_check("R4 wrap", $urandom % 320, r * 8 + $urandom % 8, 1);

        // R9 start row bounds
        cpu_wr(5, 0, 10);
        cpu_wr(5, 0, 60);
        for (int i = 0; i < 10; i++) px_check("R9 start kept", $urandom % 320, $urandom % 200, 1);
        cpu_wr(5, 0, 50);
        px_check("R9 start 50 kept", 100, 100, 1);

        // R7 cursor placement
        cpu_wr(2, 0, 5); cpu_wr(3, 0, 3);
        for (int x = 38; x < 50; x++) px_check("R7 cursor line", x, 31, 1);
        px_check("R7 other line", 42, 30, 1);
        px_check("R7 other row", 42, 39, 1);

        // R8 blink across the 16-pulse boundary
        repeat (15) tick();
        px_check("R8 visible 15", 44, 31, 1);
        tick();
        px_check("R8 hidden 16", 44, 31, 1);
        repeat (16) tick();
        px_check("R8 visible 32", 44, 31, 1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int k;
            k = $urandom % 10;
            if (k == 0) cpu_wr(4, 0, $urandom % 4);
            else if (k == 1) cpu_wr(5, 0, $urandom % 64);
            else if (k == 2) begin cpu_wr(2, 0, $urandom % 40); cpu_wr(3, 0, $urandom % 25); end
            else if (k == 3) cpu_wr(0, $urandom % 2000, $urandom % 256);
            else if (k == 4) cpu_wr(1, $urandom % 2048, $urandom % 256);
            else if (k == 5) tick();
            px_check("R2 random", $urandom % 340, $urandom % 210, ($urandom % 8) != 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule